// File: doc/BRIEF.md
# Low-Frequency Receiver Power Sequencer

This block decides, cycle by cycle, whether the low-frequency receiver front end and its telegram decoder are powered. In periodic operation it waits in OFF for a sampling-slot tick, opens an ON window of programmable length in SNIFF (front end listening for carrier), and moves to RECEIVE (front end and decoder both on) when carrier appears. Decoder completion and decoder error strobes end a reception. What follows depends on the configured mode: back to listening for the rest of the window, off until the next slot, or a short powered-down GAP before an automatic restart.

In continuous operation the receiver restarts itself instead of waiting for a slot. A toggle option makes every window end pass through GAP and invert the carrier-mode output, so that successive windows listen with alternating carrier settings. Clearing the enable input drops everything to OFF at once. The block then holds off for two oscillator periods before it accepts a new enable. Time is measured in oscillator ticks delivered as single-cycle strobes (`osc_tick`). Prescaling of those ticks and the decoder itself are outside the block.

States: OFF, SNIFF, RECEIVE, GAP. Transitions: OFF→SNIFF (slot tick, or at once in continuous mode, once the off-hold has expired); SNIFF→RECEIVE (carrier detected); SNIFF→SNIFF (window end, continuous without toggle: window restarts); SNIFF→GAP (window end with toggle); SNIFF→OFF (window end otherwise); RECEIVE→SNIFF (error with listen-on-error set); RECEIVE→OFF (error with listen-on-error clear, or done in periodic mode); RECEIVE→GAP (done in continuous mode); GAP→SNIFF (three oscillator ticks counted); any→OFF (enable low).

Top module: `lf_power_seq`

## Requirements
- R1: After reset the block is in OFF with `fe_en`, `dec_en` and `carrier_mode` all 0.
- R2: `fe_en` is 1 exactly in SNIFF and RECEIVE; `dec_en` is 1 only in RECEIVE; OFF and GAP drive both to 0.
- R3: In periodic mode (`cont_mode`=0), OFF with enable high moves to SNIFF on the clock where `sample_tick` is 1 and loads the window from `on_len`; carrier, done and error strobes have no effect in OFF.
- R4: SNIFF moves to RECEIVE when `carrier_det` is 1. The window counts down one per `osc_tick` in SNIFF and RECEIVE. When it reaches zero in SNIFF with `toggle_mode`=0 and `cont_mode`=0, the block returns to OFF. An `on_len` of 0 ends the window on the cycle after entry.
- R5: A decoder error in RECEIVE with `on_mode`=1 returns to SNIFF, and the window keeps its remaining count without reloading.
- R6: A decoder error in RECEIVE with `on_mode`=0 goes to OFF. In periodic mode the block then waits there for the next `sample_tick`.
- R7: When `dec_err` and `dec_done` are both 1 in the same RECEIVE cycle, the error action is taken.
- R8: `dec_done` in RECEIVE goes to OFF in periodic mode and to GAP in continuous mode.
- R9: GAP lasts until exactly three `osc_tick` strobes have been counted, then the block returns to SNIFF with the window reloaded.
- R10: In continuous mode, OFF moves to SNIFF with no slot tick as soon as the off-hold allows. A window end in SNIFF without toggle reloads the window and stays in SNIFF.
- R11: With `toggle_mode`=1, a window end in SNIFF goes to GAP and inverts `carrier_mode` on that same clock.
- R12: `enable`=0 forces OFF on the next clock from any state.
- R13: After `enable` falls, a new enable (including any `sample_tick`) is ignored until two `osc_tick` strobes have been counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Receiver enable |
| on_mode | input | 1 | 1: on error keep listening for the rest of the window; 0: turn off |
| cont_mode | input | 1 | 1: continuous operation with auto restart; 0: periodic sampling |
| toggle_mode | input | 1 | 1: every window end passes through GAP and inverts carrier mode |
| sample_tick | input | 1 | Start-of-sampling-slot strobe |
| osc_tick | input | 1 | One strobe per oscillator period |
| on_len | input | WIN_W | ON window length in oscillator ticks |
| carrier_det | input | 1 | Carrier detected by the front end |
| dec_done | input | 1 | Decoder finished a telegram |
| dec_err | input | 1 | Decoder found an error |
| fe_en | output | 1 | Front-end power enable |
| dec_en | output | 1 | Decoder enable |
| carrier_mode | output | 1 | Carrier-mode select, inverted on each toggled restart |

## Verification
The decoder can signal completion and error in the same RECEIVE cycle. The bench raises both strobes together with `on_mode`=1, so the two outcomes lead to different states: the error action gives SNIFF with the front end on, while done in periodic mode would give OFF. The outputs one clock later show which one won. A second collision is a window end in SNIFF landing on the clock that toggles and restarts. This is provoked in continuous mode, and the bench checks that GAP and the inverted carrier mode appear together.

// File: rtl/lfps_pkg.sv
package lfps_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SNIFF = 2'd1,
        ST_RECV  = 2'd2,
        ST_GAP   = 2'd3
    } lfps_state_e;

endpackage

// File: rtl/lfps_down_cnt.sv
// Loadable down counter that stops at zero; load wins over tick.
module lfps_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R9/R13: a counter at zero never wraps on a tick
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && tick && !load) |=> zero);

    // R9: a load of a nonzero value leaves the counter nonzero
    p_load_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val != '0)) |=> !zero);

endmodule

// File: rtl/lfps_fsm.sv
module lfps_fsm
    import lfps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        on_mode,
    input  logic        cont_mode,
    input  logic        toggle_mode,
    input  logic        sample_tick,
    input  logic        carrier_det,
    input  logic        dec_done,
    input  logic        dec_err,
    input  logic        win_zero,
    input  logic        gap_zero,
    input  logic        off_zero,
    output lfps_state_e state,
    output logic        win_load,
    output logic        gap_load,
    output logic        off_load,
    output logic        fe_en,
    output logic        dec_en,
    output logic        carrier_mode
);

    lfps_state_e nxt;
    logic        enable_q;
    logic        flip;

    // state register and enable history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_OFF;
            enable_q     <= 1'b0;
            carrier_mode <= 1'b0;
        end else begin
            state    <= nxt;
            enable_q <= enable;
            if (flip) begin
                carrier_mode <= ~carrier_mode;
            end
        end
    end

    assign off_load = enable_q & ~enable;

    // next state and per-transition strobes
    always_comb begin
        nxt      = state;
        win_load = 1'b0;
        gap_load = 1'b0;
        flip     = 1'b0;
        if (!enable) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (off_zero && (cont_mode || sample_tick)) begin
                        nxt      = ST_SNIFF;
                        win_load = 1'b1;
                    end
                end
                ST_SNIFF: begin
                    if (carrier_det) begin
                        nxt = ST_RECV;
                    end else if (win_zero) begin
                        if (toggle_mode) begin
                            nxt      = ST_GAP;
                            gap_load = 1'b1;
                            flip     = 1'b1;
                        end else if (cont_mode) begin
                            win_load = 1'b1;
                        end else begin
                            nxt = ST_OFF;
                        end
                    end
                end
                ST_RECV: begin
                    if (dec_err) begin
                        nxt = on_mode ? ST_SNIFF : ST_OFF;
                    end else if (dec_done) begin
                        if (cont_mode) begin
                            nxt      = ST_GAP;
                            gap_load = 1'b1;
                        end else begin
                            nxt = ST_OFF;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_zero) begin
                        nxt      = ST_SNIFF;
                        win_load = 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        fe_en  = 1'b0;
        dec_en = 1'b0;
        unique case (state)
            ST_OFF:   ;
            ST_SNIFF: fe_en = 1'b1;
            ST_RECV: begin
                fe_en  = 1'b1;
                dec_en = 1'b1;
            end
            ST_GAP:   ;
        endcase
    end

    p_disable_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_OFF));

    p_err_listen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_RECV && dec_err && on_mode) |=> (state == ST_SNIFF));

    p_err_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_RECV && dec_err && !on_mode) |=> (state == ST_OFF));

    p_off_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !off_zero) |=> (state == ST_OFF));

    p_flip_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_mode != $past(carrier_mode)) |-> (state == ST_GAP));

    p_gap_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (!fe_en && !dec_en));

endmodule

// File: rtl/lf_power_seq.sv
module lf_power_seq
    import lfps_pkg::*;
#(
    parameter int WIN_W     = 8,
    parameter int GAP_TICKS = 3,
    parameter int OFF_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             on_mode,
    input  logic             cont_mode,
    input  logic             toggle_mode,
    input  logic             sample_tick,
    input  logic             osc_tick,
    input  logic [WIN_W-1:0] on_len,
    input  logic             carrier_det,
    input  logic             dec_done,
    input  logic             dec_err,
    output logic             fe_en,
    output logic             dec_en,
    output logic             carrier_mode
);

    localparam int GAP_W = $clog2(GAP_TICKS + 1);
    localparam int OFF_W = $clog2(OFF_TICKS + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_TICKS);
    localparam logic [OFF_W-1:0] OFF_LOAD = OFF_W'(OFF_TICKS);

    lfps_state_e state;
    logic win_load, gap_load, off_load;
    logic win_zero, gap_zero, off_zero;
    logic win_tick, gap_tick;

    assign win_tick = osc_tick && (state == ST_SNIFF || state == ST_RECV);
    assign gap_tick = osc_tick && (state == ST_GAP);

    lfps_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .on_mode      (on_mode),
        .cont_mode    (cont_mode),
        .toggle_mode  (toggle_mode),
        .sample_tick  (sample_tick),
        .carrier_det  (carrier_det),
        .dec_done     (dec_done),
        .dec_err      (dec_err),
        .win_zero     (win_zero),
        .gap_zero     (gap_zero),
        .off_zero     (off_zero),
        .state        (state),
        .win_load     (win_load),
        .gap_load     (gap_load),
        .off_load     (off_load),
        .fe_en        (fe_en),
        .dec_en       (dec_en),
        .carrier_mode (carrier_mode)
    );

    lfps_down_cnt #(.W(WIN_W)) i_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (on_len),
        .tick     (win_tick),
        .zero     (win_zero)
    );

    lfps_down_cnt #(.W(GAP_W)) i_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (GAP_LOAD),
        .tick     (gap_tick),
        .zero     (gap_zero)
    );

    lfps_down_cnt #(.W(OFF_W)) i_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (off_load),
        .load_val (OFF_LOAD),
        .tick     (osc_tick),
        .zero     (off_zero)
    );

    p_dec_needs_fe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> fe_en);

    p_gap_leaves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_GAP && gap_zero) |=> (state == ST_SNIFF));

endmodule

// File: tb/test_lf_power_seq.sv
module test_lf_power_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 45;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 0, on_mode = 0, cont_mode = 0, toggle_mode = 0;
    logic       sample_tick = 0, osc_tick = 0, carrier_det = 0;
    logic       dec_done = 0, dec_err = 0;
    logic [7:0] on_len = 8'd2;
    logic       fe_en, dec_en, carrier_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lf_power_seq i_lf_power_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .on_mode(on_mode),
        .cont_mode(cont_mode), .toggle_mode(toggle_mode),
        .sample_tick(sample_tick), .osc_tick(osc_tick), .on_len(on_len),
        .carrier_det(carrier_det), .dec_done(dec_done), .dec_err(dec_err),
        .fe_en(fe_en), .dec_en(dec_en), .carrier_mode(carrier_mode)
    );

    // inputs {en,on_mode,cont,toggle,sample,osc,carrier,done,err}, expected {fe,dec,cmode}
    localparam logic [11:0] VECS [0:NVEC-1] = '{
        {9'b100000000, 3'b000},  // R3 no slot yet
        {9'b100010000, 3'b100},  // R3 slot -> SNIFF
        {9'b100001000, 3'b100},  // R4 window 1
        {9'b100000100, 3'b110},  // R4 carrier -> RECEIVE
        {9'b100000010, 3'b000},  // R8 done periodic -> OFF
        {9'b100010000, 3'b100},  // R3
        {9'b100001000, 3'b100},  // R4
        {9'b100001000, 3'b100},  // R4 window 0
        {9'b100000000, 3'b000},  // R4 window end -> OFF
        {9'b110010000, 3'b100},  // R3
        {9'b110000100, 3'b110},  // R4
        {9'b110000001, 3'b100},  // R5 error listen -> SNIFF
        {9'b110001000, 3'b100},  // R5 window not reloaded
        {9'b110001000, 3'b100},  // R5
        {9'b110000000, 3'b000},  // R5 window ends on old count
        {9'b100010000, 3'b100},  // R3
        {9'b100000100, 3'b110},  // R4
        {9'b100000001, 3'b000},  // R6 error -> OFF
        {9'b100000100, 3'b000},  // R6 waits for slot, carrier ignored
        {9'b100010000, 3'b100},  // R3
        {9'b100000100, 3'b110},  // R4
        {9'b110000011, 3'b100},  // R7 error wins over done
        {9'b000000000, 3'b000},  // R12 disable
        {9'b101000000, 3'b000},  // R13 hold
        {9'b101001000, 3'b000},  // R13
        {9'b101001000, 3'b000},  // R13
        {9'b101000000, 3'b100},  // R10 continuous start
        {9'b101000100, 3'b110},  // R4
        {9'b101000010, 3'b000},  // R8 done continuous -> GAP
        {9'b101001000, 3'b000},  // R9
        {9'b101001000, 3'b000},  // R9
        {9'b101000000, 3'b000},  // R9 no tick
        {9'b101001000, 3'b000},  // R9 third tick
        {9'b101000000, 3'b100},  // R9 -> SNIFF
        {9'b101101000, 3'b100},  // R11
        {9'b101101000, 3'b100},  // R11
        {9'b101100000, 3'b001},  // R11 GAP + invert
        {9'b101101000, 3'b001},  // R9
        {9'b101101000, 3'b001},  // R9
        {9'b101101000, 3'b001},  // R9
        {9'b101100000, 3'b101},  // R11 restart inverted
        {9'b101001000, 3'b101},  // R10
        {9'b101001000, 3'b101},  // R10
        {9'b101000000, 3'b101},  // R10 window restart stays SNIFF
        {9'b001000000, 3'b001}   // R12 disable
    };
    localparam int VTAG [0:NVEC-1] = '{
        3,3,4,4,8,3,4,4,4,3,4,5,5,5,5,3,4,6,6,3,4,7,12,13,13,13,10,4,8,9,9,9,9,9,
        11,11,11,9,9,9,11,10,10,10,12
    };

    task automatic apply(input logic [8:0] v);
        @(negedge clk);
        {enable, on_mode, cont_mode, toggle_mode, sample_tick, osc_tick,
         carrier_det, dec_done, dec_err} = v;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [2:0] exp);
        n_chk++;
        if ({fe_en, dec_en, carrier_mode} !== exp) begin
            n_bad++;
            $display("FAIL %s: {fe,dec,cmode} actual %b expected %b",
                     tag, {fe_en, dec_en, carrier_mode}, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {enable, on_mode, cont_mode, toggle_mode, sample_tick, osc_tick,
         carrier_det, dec_done, dec_err} = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][11:3]);
            check($sformatf("R%0d vec %0d", VTAG[i], i), VECS[i][2:0]);
        end

        // R1: reset after carrier mode was inverted clears it
        do_reset();

        // R12: disable while receiving
        apply(9'b100010000); check("R12 to SNIFF", 3'b100);
        apply(9'b100000100); check("R12 to RECEIVE", 3'b110);
        apply(9'b000000000); check("R12 disable in RECEIVE", 3'b000);

        // R13: slot tick during off-hold is ignored
        apply(9'b100010000); check("R13 slot during hold", 3'b000);
        apply(9'b100011000); check("R13 slot with tick 1", 3'b000);
        apply(9'b100011000); check("R13 slot with tick 2", 3'b000);
        apply(9'b100010000); check("R13 slot after hold", 3'b100);

        // R4: zero-length window
        do_reset();
        on_len = 8'd0;
        apply(9'b100010000); check("R4 zero window open", 3'b100);
        apply(9'b100000000); check("R4 zero window close", 3'b000);
        on_len = 8'd2;

        // R2: GAP powers everything down, dec only in RECEIVE
        apply(9'b101000000); check("R2 continuous SNIFF", 3'b100);
        apply(9'b101000100); check("R2 RECEIVE", 3'b110);
        apply(9'b101000010); check("R2 GAP dark", 3'b000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule